// File: doc/BRIEF.md
# Triple Dot-Product Pixel Engine

This block is a pipelined arithmetic engine built from three identical vector multiplication units that run in parallel. Each unit takes three 8-bit pixel operands, multiplies them by its own row of three programmable signed coefficients, and sums the three products. After the sum, a unit either adds a programmable integer offset or folds the sum into a private running accumulator. The last stage rounds each result to the nearest integer, ties upward, and clamps it to the 0..255 pixel range.

Two uses share one datapath. In colour-space mode the three units form a 3x3 matrix applied to the incoming three-component pixel, plus a per-lane offset. This covers any conversion matrix that software loads, such as RGB to YUV or its inverse. In filter mode a nine-entry sample history, fed from component 0, gives each unit three consecutive taps. The three partial sums are then merged into one nine-tap FIR output per accepted sample. The accumulating variants of both modes let longer filters, or sums spread over several passes, be built up before the result is read. A synchronous clear pulse empties all three accumulators between passes. Input and output use valid/ready handshakes, and any backpressure stalls the whole pipeline.

Top module: `tri_dot_engine`

## Requirements
- R1: While and straight after a synchronous reset, `out_valid` is 0, `out_pix` is 0, `in_ready` is 1, all accumulators are 0 and the sample history is all zero.
- R2: In mode 2'b00, lane k (bits [8k+7:8k] of `out_pix`) equals clamp(round(sum over j of C[3k+j]*p[j] + O[k]*256)). Here p[j] is bits [8j+7:8j] of `in_pix`, C[i] is the 12-bit signed field at bits [12i+11:12i] of `coef`, and O[k] is the 16-bit signed field at bits [16k+15:16k] of `offs`.
- R3: Rounding adds 128 (half an output LSB at 8 fractional bits) and then shifts right arithmetically by 8, so a fraction of exactly one half rounds upward.
- R4: After rounding, a negative value gives 0 and a value above 255 gives 255.
- R5: A beat accepted on a rising edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after the third rising edge, counting the accepting edge as the first. Without backpressure, one beat is accepted and one result is produced every cycle.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_valid` hold their values and `in_ready` is 0. No result is lost or duplicated.
- R7: In mode 2'b01, unit k adds its dot product to accumulator k, and lane k shows clamp(round(new accumulator value)). The offsets are not used.
- R8: In mode 2'b10, lane 0 equals clamp(round(sum over i=0..8 of C[i]*x[n-i] + O[0]*256)), and lanes 1 and 2 are 0. Here x[n] is component 0 of the current beat, x[n-i] is component 0 of the beat accepted i beats earlier in any mode, and samples before reset count as 0.
- R9: In mode 2'b11, unit k adds its three-tap partial sum (C[3k+j]*x[n-3k-j]) to accumulator k. Lane 0 shows clamp(round(sum of the three new accumulator values)), and lanes 1 and 2 are 0.
- R10: A one-cycle pulse on `acc_clr` while no accumulating beat is in flight sets all three accumulators to 0, so the next accumulating beat starts from its own dot product.
- R11: In modes 2'b10 and 2'b11, components 1 and 2 of `in_pix` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Engine accepts a beat this cycle |
| in_pix | input | 24 | Three unsigned 8-bit components, component j at [8j+7:8j] |
| coef | input | 108 | Nine signed 12-bit coefficients with 8 fractional bits, C[i] at [12i+11:12i] |
| offs | input | 48 | Three signed 16-bit integer offsets, O[k] at [16k+15:16k] |
| mode | input | 2 | 00 matrix+offset, 01 matrix accumulate, 10 FIR+offset, 11 FIR accumulate |
| acc_clr | input | 1 | Synchronous pulse that zeroes the three accumulators |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pix | output | 24 | Three clamped 8-bit results, lane k at [8k+7:8k] |

## Verification
The bench builds the engine with its default parameters: 8-bit pixels, 12-bit coefficients with 8 fractional bits, 16-bit offsets and 32-bit accumulators. At 8 bits, every component value can be swept for the identity matrix and for the half-weight coefficient, which exercises every rounding tie. Coefficients near both ends of the 12-bit range drive both clamp limits. The bench keeps its own nine-sample history and its own accumulators, so long FIR streams, multi-pass accumulation and clear pulses are all predicted arithmetically. It checks them under random output backpressure and again with backpressure off, where the exact latency is also measured.

// File: rtl/tde_pkg.sv
package tde_pkg;

  localparam int LANES = 3;
  localparam int TAPS  = LANES * LANES;

  typedef enum logic [1:0] {
    MODE_CSC    = 2'b00,
    MODE_ACC    = 2'b01,
    MODE_FIR    = 2'b10,
    MODE_FIRACC = 2'b11
  } tde_mode_e;

  function automatic logic mode_is_fir(tde_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_acc(tde_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/tde_tapline.sv
module tde_tapline #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift,
  input  logic [PIX_W-1:0]       din,
  output logic [DEPTH*PIX_W-1:0] taps
);

  localparam int HIST = DEPTH - 1;

  logic [PIX_W-1:0] hist [HIST];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else if (shift) begin
      hist[0] <= din;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  // tap 0 is the sample being accepted, tap i the one accepted i beats earlier
  always_comb begin
    taps[PIX_W-1:0] = din;
    for (int i = 1; i < DEPTH; i++) taps[i*PIX_W +: PIX_W] = hist[i-1];
  end

endmodule

// File: rtl/tde_vmu.sv
module tde_vmu
  import tde_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int OFS_W  = 16,
  parameter int FRAC   = 8,
  parameter int ACC_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [LANES*PIX_W-1:0]        opnd,
  input  logic [LANES*COEF_W-1:0]       cf,
  input  logic                          s1_valid,
  input  tde_mode_e                     s1_mode,
  input  logic signed [OFS_W-1:0]       off,
  input  logic                          acc_clr,
  output logic signed [ACC_W-1:0]       u_val
);

  localparam int PROD_W = PIX_W + 1 + COEF_W;

  logic signed [PROD_W-1:0] prod_q [LANES];
  logic signed [ACC_W-1:0]  dot, off_ext, acc_q, acc_next;
  logic                     upd;

  // stage 1: three products, pixel treated as non-negative
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LANES; j++) prod_q[j] <= '0;
    end else if (en) begin
      for (int j = 0; j < LANES; j++)
        prod_q[j] <= $signed({1'b0, opnd[j*PIX_W +: PIX_W]}) *
                     $signed(cf[j*COEF_W +: COEF_W]);
    end
  end

  always_comb begin
    dot = '0;
    for (int j = 0; j < LANES; j++) dot = dot + ACC_W'(prod_q[j]);
    off_ext  = ACC_W'(off) <<< FRAC;
    acc_next = (acc_clr ? ACC_W'(0) : acc_q) + dot;
    upd      = en && s1_valid && mode_is_acc(s1_mode);
  end

  // stage 2: offset add or accumulate
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      u_val <= '0;
    end else begin
      if (upd)          acc_q <= acc_next;
      else if (acc_clr) acc_q <= '0;
      if (en) u_val <= mode_is_acc(s1_mode) ? acc_next : dot + off_ext;
    end
  end

  // R10
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    acc_clr && !upd |=> acc_q == '0);

endmodule

// File: rtl/tde_rndsat.sv
module tde_rndsat #(
  parameter int IN_W  = 34,
  parameter int FRAC  = 8,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0] val,
  output logic [OUT_W-1:0]       res
);

  localparam logic signed [IN_W-1:0] HALF = IN_W'(1 << (FRAC - 1));
  localparam logic signed [IN_W-1:0] TOP  = IN_W'((1 << OUT_W) - 1);

  logic signed [IN_W-1:0] sh;

  always_comb begin
    sh = (val + HALF) >>> FRAC;
    if (sh < 0)        res = '0;
    else if (sh > TOP) res = '1;
    else               res = sh[OUT_W-1:0];
  end

endmodule

// File: rtl/tri_dot_engine.sv
module tri_dot_engine
  import tde_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int OFS_W  = 16,
  parameter int FRAC   = 8,
  parameter int ACC_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*PIX_W-1:0]  in_pix,
  input  logic [TAPS*COEF_W-1:0]  coef,
  input  logic [LANES*OFS_W-1:0]  offs,
  input  logic [1:0]              mode,
  input  logic                    acc_clr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*PIX_W-1:0]  out_pix
);

  localparam int SUM_W = ACC_W + 2;
  localparam int ROW_P = LANES * PIX_W;
  localparam int ROW_C = LANES * COEF_W;

  logic      en, fire;
  tde_mode_e in_mode, s1_mode;
  logic      s1_valid, s2_valid, s2_fir, out_fir;
  logic [TAPS*PIX_W-1:0]   taps;
  logic signed [ACC_W-1:0] u_val    [LANES];
  logic signed [SUM_W-1:0] lane_val [LANES];
  logic [PIX_W-1:0]        rs_val   [LANES];

  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign fire     = in_valid && en;
  assign in_mode  = tde_mode_e'(mode);

  tde_tapline #(.PIX_W(PIX_W), .DEPTH(TAPS)) u_taps (
    .clk   (clk),
    .rst   (rst),
    .shift (fire),
    .din   (in_pix[PIX_W-1:0]),
    .taps  (taps)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_mode   <= MODE_CSC;
      s2_valid  <= 1'b0;
      s2_fir    <= 1'b0;
      out_valid <= 1'b0;
      out_fir   <= 1'b0;
    end else if (en) begin
      s1_valid  <= fire;
      s1_mode   <= in_mode;
      s2_valid  <= s1_valid;
      s2_fir    <= mode_is_fir(s1_mode);
      out_valid <= s2_valid;
      out_fir   <= s2_fir;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : gen_unit
    logic [ROW_P-1:0]        opnd;
    logic signed [OFS_W-1:0] off_q;

    assign opnd = mode_is_fir(in_mode) ? taps[k*ROW_P +: ROW_P] : in_pix;

    always_ff @(posedge clk) begin
      if (rst)     off_q <= '0;
      else if (en) off_q <= (k != 0 && mode_is_fir(in_mode)) ? '0 : offs[k*OFS_W +: OFS_W];
    end

    tde_vmu #(
      .PIX_W (PIX_W), .COEF_W(COEF_W), .OFS_W(OFS_W), .FRAC(FRAC), .ACC_W(ACC_W)
    ) u_vmu (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .opnd     (opnd),
      .cf       (coef[k*ROW_C +: ROW_C]),
      .s1_valid (s1_valid),
      .s1_mode  (s1_mode),
      .off      (off_q),
      .acc_clr  (acc_clr),
      .u_val    (u_val[k])
    );

    tde_rndsat #(.IN_W(SUM_W), .FRAC(FRAC), .OUT_W(PIX_W)) u_rs (
      .val (lane_val[k]),
      .res (rs_val[k])
    );
  end

  // FIR merges the three partial sums into lane 0
  always_comb begin
    for (int k = 0; k < LANES; k++)
      lane_val[k] = s2_fir ? SUM_W'(0) : SUM_W'(u_val[k]);
    if (s2_fir)
      for (int k = 0; k < LANES; k++) lane_val[0] = lane_val[0] + SUM_W'(u_val[k]);
  end

  always_ff @(posedge clk) begin
    if (rst)     out_pix <= '0;
    else if (en)
      for (int k = 0; k < LANES; k++) out_pix[k*PIX_W +: PIX_W] <= rs_val[k];
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  // R5
  fire_to_s1_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> s1_valid);

  // R8
  fir_lanes_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_fir |-> out_pix[LANES*PIX_W-1:PIX_W] == '0);

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    en && s2_valid && lane_val[0] < 0 |=> out_pix[PIX_W-1:0] == '0);

endmodule

// File: tb/tri_dot_engine_bench.sv
module tri_dot_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 12;
  localparam int OFS_W  = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst, in_valid, in_ready, acc_clr, out_valid, out_ready;
  logic [23:0] in_pix, out_pix;
  logic [107:0] coef;
  logic [47:0] offs;
  logic [1:0]  mode;

  int cf [9];
  int off [3];

  always_comb begin
    for (int i = 0; i < 9; i++) coef[i*COEF_W +: COEF_W] = COEF_W'(cf[i]);
    for (int i = 0; i < 3; i++) offs[i*OFS_W +: OFS_W] = OFS_W'(off[i]);
  end

  tri_dot_engine u_tri_dot_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .coef(coef), .offs(offs), .mode(mode), .acc_clr(acc_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, seed = 7;
  bit bp_on = 0, hold_pending = 0;
  logic [23:0] held;
  logic [15:0] lfsr = 16'hACE1;
  string cur_tag;
  int q_e0[$], q_e1[$], q_e2[$], q_cyc[$];
  bit q_lat[$];
  string q_tag[$];
  int hist [9];
  longint macc [3];

  function automatic int rnd8();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  function automatic int rs(longint v);
    longint t = (v + 128) >>> 8;
    if (t < 0) return 0;
    if (t > 255) return 255;
    return int'(t);
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic push_model();
    longint d [3];
    int c [3];
    int e [3];
    for (int j = 0; j < 3; j++) c[j] = int'(in_pix[j*8 +: 8]);
    for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = c[0];
    for (int k = 0; k < 3; k++) begin
      d[k] = 0;
      for (int j = 0; j < 3; j++)
        d[k] += longint'(cf[3*k+j]) * longint'(mode[1] ? hist[3*k+j] : c[j]);
    end
    case (mode)
      2'b00: for (int k = 0; k < 3; k++) e[k] = rs(d[k] + longint'(off[k]) * 256);
      2'b01: for (int k = 0; k < 3; k++) begin macc[k] += d[k]; e[k] = rs(macc[k]); end
      2'b10: begin e[0] = rs(d[0] + d[1] + d[2] + longint'(off[0]) * 256); e[1] = 0; e[2] = 0; end
      default: begin
        for (int k = 0; k < 3; k++) macc[k] += d[k];
        e[0] = rs(macc[0] + macc[1] + macc[2]); e[1] = 0; e[2] = 0;
      end
    endcase
    q_e0.push_back(e[0]); q_e1.push_back(e[1]); q_e2.push_back(e[2]);
    q_cyc.push_back(cyc); q_lat.push_back(!bp_on); q_tag.push_back(cur_tag);
  endtask

  task automatic step(output bit took);
    if (bp_on) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
    end else out_ready = 1'b1;
    #1;
    if (hold_pending) begin
      check("R6 held valid", int'(out_valid), 1);
      check("R6 held data", int'(out_pix), int'(held));
    end
    hold_pending = out_valid && !out_ready;
    held = out_pix;
    if (out_valid && !out_ready) check("R6 in_ready low in stall", int'(in_ready), 0);
    if (out_valid && out_ready) begin
      if (q_e0.size() == 0) check("R5 output without input", 1, 0);
      else begin
        string t = q_tag.pop_front();
        int pc = q_cyc.pop_front();
        bit lt = q_lat.pop_front();
        check({t, " lane0"}, int'(out_pix[7:0]), q_e0.pop_front());
        check({t, " lane1"}, int'(out_pix[15:8]), q_e1.pop_front());
        check({t, " lane2"}, int'(out_pix[23:16]), q_e2.pop_front());
        if (lt && !bp_on) check("R5 latency", cyc - pc, 3);
      end
    end
    took = in_valid && in_ready;
    if (took) push_model();
    @(negedge clk);
    cyc++;
  endtask

  task automatic send(string tag, logic [1:0] m, int c0, int c1, int c2);
    bit took;
    cur_tag = tag;
    mode = m;
    in_pix = {8'(c2), 8'(c1), 8'(c0)};
    in_valid = 1'b1;
    do step(took); while (!took);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    bit took;
    in_valid = 1'b0;
    for (int i = 0; i < 200 && (q_e0.size() != 0); i++) step(took);
    step(took);
  endtask

  task automatic clear_acc();
    bit took;
    acc_clr = 1'b1;
    step(took);
    acc_clr = 1'b0;
    for (int k = 0; k < 3; k++) macc[k] = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog expired: got hung expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; acc_clr = 1'b0;
    in_pix = '0; mode = 2'b00;
    for (int i = 0; i < 9; i++) begin cf[i] = 0; hist[i] = 0; end
    for (int k = 0; k < 3; k++) begin off[k] = 0; macc[k] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_pix after reset", int'(out_pix), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    @(negedge clk);

    // R2 identity matrix, R5 streaming latency
    cf[0] = 256; cf[4] = 256; cf[8] = 256;
    for (int c = 0; c < 256; c += 3) send("R2 identity", 2'b00, c, 255 - c, c ^ 8'h5a);
    drain();

    // R2 colour matrix with offsets, half of it under backpressure (R6)
    cf = '{66, 129, 25, -38, -74, 112, 112, -94, -18};
    off = '{16, 128, 128};
    for (int i = 0; i < 160; i++) begin
      bp_on = (i >= 80);
      send("R2 matrix", 2'b00, rnd8(), rnd8(), rnd8());
    end
    drain(); bp_on = 0; drain();

    // R3 half weight: every tie rounds upward
    cf = '{128, 0, 0, 0, 0, 0, 0, 0, 0};
    off = '{0, 0, 0};
    for (int c = 0; c < 256; c++) send("R3 rounding", 2'b00, c, 0, 0);
    drain();

    // R4 clamping at both ends
    cf = '{2047, 2047, 2047, -2048, -2048, 0, 0, 100, 0};
    off = '{0, 50, 300};
    for (int c = 0; c < 256; c += 5) send("R4 clamp", 2'b00, c, 255 - c, c);
    drain();

    // R7 per-lane accumulation under backpressure
    clear_acc();
    cf = '{64, 32, -16, 10, 20, 30, -50, 5, 90};
    bp_on = 1;
    for (int i = 0; i < 24; i++) send("R7 accumulate", 2'b01, rnd8(), rnd8(), rnd8());
    drain(); bp_on = 0; drain();

    // R8 R11 nine-tap FIR with random side components
    for (int i = 0; i < 9; i++) cf[i] = ((rnd8() << 4) - 2048) / 8;
    off = '{5, -700, 900};
    for (int i = 0; i < 120; i++) begin
      bp_on = (i % 40) >= 20;
      send("R8 R11 fir", 2'b10, rnd8(), rnd8(), rnd8());
    end
    drain(); bp_on = 0; drain();

    // R9 multi-pass FIR accumulation
    clear_acc();
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 9; i++) cf[i] = (rnd8() - 128) / 4;
      for (int i = 0; i < 12; i++) send("R9 R11 fir accumulate", 2'b11, rnd8(), rnd8(), rnd8());
    end
    drain();

    // R10 clear then a fresh accumulation starts from one dot product
    clear_acc();
    cf = '{100, 0, 0, 0, 50, 0, 0, 0, 25};
    send("R10 after clear", 2'b01, 200, 100, 40);
    send("R10 second beat", 2'b01, 10, 20, 30);
    drain();

    summary();
    $finish;
  end

endmodule